// File: doc/BRIEF.md
# Direct-Mapped First-Level Cache Controller

This block is a direct-mapped first-level cache placed between a processor that issues single-word loads and stores and a slower lower-level memory that moves whole lines. Each request is tagged by its address. A hit finishes in one cycle. A miss runs a fixed sequence of line transfers on the lower-level port. Each transfer holds its request until the lower level signals the end of a 10-cycle transfer. The design keeps one tag, one valid bit and one dirty bit per line, and it keeps the line data in a single-port array that maps onto block RAM.

A build-time parameter selects the write policy. With write-back, stores stay in the cache and set the dirty bit. A dirty victim is copied out in full before the replacement line is fetched. With write-through and write-allocate, every store is also sent to the lower level as a single-word write with a one-hot word strobe. No line is ever dirty in this mode, and a victim is simply dropped. The processor side handles one request at a time. It reports readiness while idle and gives a one-cycle completion pulse with the read word once the whole access, including any miss traffic, is finished.

With the default sizes the byte address splits as follows: bits 3:0 select a byte within a 16-byte line, bits 3:2 pick one of four 32-bit words, bits 14:4 pick one of 2048 lines, and bits 31:15 form the 17-bit tag. This gives 32 KB of data.

Top module: `l1_dm_cache`

## Requirements
- R1: Address bits 14:4 select the line and bits 31:15 are the stored tag. Bits 3:2 select the word within a 128-bit line, with word w at line bits 32w+31:32w. Every fill and every write-through presents line address bits 31:4 of the request, and every victim write-back presents the stored tag concatenated with the index.
- R2: After reset, req_ready is 1 and resp_done and mem_req are 0. Every line is invalid, so the first access to any address after reset is a miss, even if that line was cached before the reset.
- R3: A read hit, and a write hit under write-back, raise resp_done in the cycle after the request cycle (latency 1) without touching the lower-level port.
- R4: Each lower-level transfer keeps mem_req high, with line address, direction and write data held stable, until mem_done. A transfer lasts 10 cycles, and each transfer adds 10 cycles to the access latency.
- R5: Under write-back, a miss whose victim is invalid or clean performs only a line fill (latency 11). A read miss leaves the line clean, and a write miss merges the store into the filled line and leaves it dirty.
- R6: Under write-back, a miss whose victim is dirty first writes the whole victim line with all four word strobes set, then fills (latency 21).
- R7: Under write-back, a store makes no lower-level write until its line is evicted. Later reads of that word, from the cache or after re-fetching, return the stored value.
- R8: Under write-through, a read miss never writes back the victim and takes only the fill (latency 11).
- R9: Under write-through, a write miss first sends the word to the lower level with a one-hot strobe (10 cycles), then fills the line (10 cycles), for a latency of 21.
- R10: Under write-through, a write hit updates the cached line and sends one single-word write (latency 11). A line never becomes dirty, so evictions never cause write-backs.
- R11: Only one request is outstanding at a time. req_ready is low from acceptance until resp_done, and a req_valid raised while busy is ignored.
- R12: Every read returns the most recently stored value for its address, under both policies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Idle and able to take a request |
| resp_done | output | 1 | One-cycle pulse when the access is complete |
| resp_rdata | output | 32 | Load data, valid with resp_done |
| mem_req | output | 1 | Lower-level transfer in progress |
| mem_write | output | 1 | 1 = write to lower level, 0 = line fill |
| mem_line_addr | output | 28 | Line address (byte address bits 31:4) |
| mem_wdata | output | 128 | Line or replicated-word write data |
| mem_wstrb | output | 4 | Word enables for a lower-level write |
| mem_done | input | 1 | End-of-transfer pulse from the lower level |
| mem_rdata | input | 128 | Fill data, valid with mem_done |

## Verification
The bench drives both policy variants with the same access stream. That stream repeatedly conflicts on one index with three different tags, so a victim that is clean, dirty or invalid arises under each policy. It also covers the top index paired with the maximum tag. If a design dropped the dirty write-back, the data read back later would be stale. If it wrote back clean lines, or added or skipped a transfer, the latency would land at the wrong multiple of ten. A request raised while the block is busy must not reach the array, and a design that accepted it would return altered data at that address. A reset in the middle of the run must turn a known hit back into an 11-cycle miss. A design that did not clear the valid bits would answer after one cycle.

// File: rtl/l1c_pkg.sv
package l1c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_EVICT,
    ST_THRU,
    ST_FILL
  } l1c_state_e;
endpackage

// File: rtl/l1_sp_ram.sv
// Single-port synchronous RAM, read data registered, suitable for block RAM.
module l1_sp_ram #(
  parameter int ADDR_BITS = 11,
  parameter int DATA_BITS = 128
) (
  input  logic                 clk,
  input  logic                 en,
  input  logic                 we,
  input  logic [ADDR_BITS-1:0] addr,
  input  logic [DATA_BITS-1:0] wdata,
  output logic [DATA_BITS-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_BITS;

  logic [DATA_BITS-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      else    rdata       <= store[addr];
    end
  end
endmodule

// File: rtl/l1_valid_vec.sv
// Per-line valid flags held in flops so that reset clears all of them.
module l1_valid_vec #(
  parameter int IDX_BITS = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set,
  input  logic [IDX_BITS-1:0] set_idx,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic                rd_valid
);
  localparam int LINES = 1 << IDX_BITS;

  logic [LINES-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst)      flags          <= '0;
    else if (set) flags[set_idx] <= 1'b1;
  end

  assign rd_valid = flags[rd_idx];

  // R2: the cycle after reset is released, no line is valid
  a_r2_all_invalid: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (flags == '0));
endmodule

// File: rtl/l1_dm_cache.sv
module l1_dm_cache
  import l1c_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int OFFS_W     = 4,
  parameter int IDX_W      = 11,
  parameter int WRITE_BACK = 1
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  input  logic                                   req_write,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [WORD_W-1:0]                      req_wdata,
  output logic                                   req_ready,
  output logic                                   resp_done,
  output logic [WORD_W-1:0]                      resp_rdata,
  output logic                                   mem_req,
  output logic                                   mem_write,
  output logic [ADDR_W-OFFS_W-1:0]               mem_line_addr,
  output logic [(1<<OFFS_W)*8-1:0]               mem_wdata,
  output logic [((1<<OFFS_W)*8/WORD_W)-1:0]      mem_wstrb,
  input  logic                                   mem_done,
  input  logic [(1<<OFFS_W)*8-1:0]               mem_rdata
);
  localparam int  LINE_W  = (1 << OFFS_W) * 8;
  localparam int  WORDS   = LINE_W / WORD_W;
  localparam int  WSEL_W  = $clog2(WORDS);
  localparam int  BSEL_W  = $clog2(WORD_W / 8);
  localparam int  TAG_W   = ADDR_W - OFFS_W - IDX_W;
  localparam bit  WB      = (WRITE_BACK != 0);

  l1c_state_e st;

  // latched request
  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [WSEL_W-1:0] a_wsel;
  logic              a_wr;
  logic [WORD_W-1:0] a_wdata;

  logic accept;
  assign accept    = (st == ST_IDLE) && req_valid;
  assign req_ready = (st == ST_IDLE);

  // arrays
  logic              vld;
  logic [TAG_W-1:0]  tag_q;
  logic              dirty_q;
  logic [LINE_W-1:0] line_q;
  logic              hit;
  logic              fin_wr;
  logic              ram_en;
  logic [IDX_W-1:0]  ram_addr;
  logic [LINE_W-1:0] base_line;
  logic [LINE_W-1:0] out_line;
  logic [WORDS-1:0]  word_onehot;

  assign ram_en   = accept || fin_wr;
  assign ram_addr = accept ? req_addr[OFFS_W +: IDX_W] : a_idx;

  l1_sp_ram #(.ADDR_BITS(IDX_W), .DATA_BITS(LINE_W)) u_data (
    .clk   (clk),
    .en    (ram_en),
    .we    (fin_wr),
    .addr  (ram_addr),
    .wdata (out_line),
    .rdata (line_q)
  );

  l1_sp_ram #(.ADDR_BITS(IDX_W), .DATA_BITS(TAG_W + 1)) u_tags (
    .clk   (clk),
    .en    (ram_en),
    .we    (fin_wr),
    .addr  (ram_addr),
    .wdata ({WB && a_wr, a_tag}),
    .rdata ({dirty_q, tag_q})
  );

  l1_valid_vec #(.IDX_BITS(IDX_W)) u_valid (
    .clk      (clk),
    .rst      (rst),
    .set      ((st == ST_FILL) && mem_done),
    .set_idx  (a_idx),
    .rd_idx   (a_idx),
    .rd_valid (vld)
  );

  assign hit = vld && (tag_q == a_tag);

  // line to be written back into the array, with a store merged in
  assign base_line = (st == ST_FILL) ? mem_rdata : line_q;

  always_comb begin
    for (int w = 0; w < WORDS; w++) begin
      if (a_wr && (a_wsel == WSEL_W'(w))) out_line[w*WORD_W +: WORD_W] = a_wdata;
      else                               out_line[w*WORD_W +: WORD_W] = base_line[w*WORD_W +: WORD_W];
    end
  end

  assign fin_wr = ((st == ST_LOOK) && hit && a_wr && WB) ||
                  ((st == ST_THRU) && mem_done && hit) ||
                  ((st == ST_FILL) && mem_done);

  assign word_onehot = WORDS'(1) << a_wsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      resp_done     <= 1'b0;
      resp_rdata    <= '0;
      mem_req       <= 1'b0;
      mem_write     <= 1'b0;
      mem_line_addr <= '0;
      mem_wdata     <= '0;
      mem_wstrb     <= '0;
      a_tag         <= '0;
      a_idx         <= '0;
      a_wsel        <= '0;
      a_wr          <= 1'b0;
      a_wdata       <= '0;
    end else begin
      resp_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            a_tag   <= req_addr[ADDR_W-1 -: TAG_W];
            a_idx   <= req_addr[OFFS_W +: IDX_W];
            a_wsel  <= req_addr[BSEL_W +: WSEL_W];
            a_wr    <= req_write;
            a_wdata <= req_wdata;
            st      <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit && !(a_wr && !WB)) begin
            resp_done  <= 1'b1;
            resp_rdata <= out_line[a_wsel*WORD_W +: WORD_W];
            st         <= ST_IDLE;
          end else if (a_wr && !WB) begin
            st            <= ST_THRU;
            mem_req       <= 1'b1;
            mem_write     <= 1'b1;
            mem_line_addr <= {a_tag, a_idx};
            mem_wdata     <= {WORDS{a_wdata}};
            mem_wstrb     <= word_onehot;
          end else if (vld && dirty_q) begin
            st            <= ST_EVICT;
            mem_req       <= 1'b1;
            mem_write     <= 1'b1;
            mem_line_addr <= {tag_q, a_idx};
            mem_wdata     <= line_q;
            mem_wstrb     <= '1;
          end else begin
            st            <= ST_FILL;
            mem_req       <= 1'b1;
            mem_write     <= 1'b0;
            mem_line_addr <= {a_tag, a_idx};
          end
        end
        ST_EVICT: begin
          if (mem_done) begin
            st            <= ST_FILL;
            mem_write     <= 1'b0;
            mem_line_addr <= {a_tag, a_idx};
          end
        end
        ST_THRU: begin
          if (mem_done) begin
            if (hit) begin
              st         <= ST_IDLE;
              mem_req    <= 1'b0;
              mem_write  <= 1'b0;
              resp_done  <= 1'b1;
              resp_rdata <= out_line[a_wsel*WORD_W +: WORD_W];
            end else begin
              st        <= ST_FILL;
              mem_write <= 1'b0;
            end
          end
        end
        ST_FILL: begin
          if (mem_done) begin
            st         <= ST_IDLE;
            mem_req    <= 1'b0;
            resp_done  <= 1'b1;
            resp_rdata <= out_line[a_wsel*WORD_W +: WORD_W];
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: a transfer in flight keeps its address, direction and data
  a_r4_xfer_stable: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req) && !$past(mem_done)) |->
      ($stable(mem_line_addr) && $stable(mem_write) && $stable(mem_wdata)));

  // R11: completion only arrives with the block idle, and as a single pulse
  a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
    resp_done |-> req_ready);
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    resp_done |=> !resp_done);

  // R3: a hit that needs no lower-level write finishes next cycle, no traffic
  a_r3_hit_one_cycle: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_LOOK) && hit && !(a_wr && !WB)) |=> (resp_done && !mem_req));

  // R6: write-back victims go out as whole lines
  a_r6_full_line: assert property (@(posedge clk) disable iff (rst)
    (WB && mem_req && mem_write) |-> (mem_wstrb == '1));

  // R9: write-through stores carry exactly one word strobe
  a_r9_word_strobe: assert property (@(posedge clk) disable iff (rst)
    (!WB && mem_req && mem_write) |-> ($countones(mem_wstrb) == 1));

  // R1: fills fetch the line of the latched request
  a_r1_fill_addr: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_FILL) && mem_req) |-> (mem_line_addr == {a_tag, a_idx}));
endmodule

// File: tb/sim_l1_dm_cache.sv
package sim_l1_pkg;
  function automatic logic [31:0] init_word(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'h5A5A_3C3C;
  endfunction
endpackage

// Lower-level memory model: each transfer lasts XFER cycles.
module sim_l1_lower #(
  parameter int XFER = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req,
  input  logic         wr,
  input  logic [27:0]  laddr,
  input  logic [127:0] wdata,
  input  logic [3:0]   wstrb,
  output logic         done,
  output logic [127:0] rdata
);
  import sim_l1_pkg::*;
  logic [127:0] lines [logic [27:0]];
  int cnt;
  logic [127:0] cur;

  always @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      cnt  <= 0;
    end else if (done) begin
      done <= 1'b0;
      cnt  <= 0;
    end else if (req) begin
      if (cnt == XFER - 2) begin
        done <= 1'b1;
        if (lines.exists(laddr)) cur = lines[laddr];
        else for (int w = 0; w < 4; w++) cur[w*32 +: 32] = init_word({laddr, w[1:0], 2'b00});
        if (wr) begin
          for (int w = 0; w < 4; w++) if (wstrb[w]) cur[w*32 +: 32] = wdata[w*32 +: 32];
          lines[laddr] = cur;
        end else begin
          rdata <= cur;
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end
endmodule

module sim_l1_dm_cache;
  import sim_l1_pkg::*;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;

  logic         rdy0, rdy1, dn0, dn1;
  logic [31:0]  rd0, rd1;
  logic         mq0, mq1, mw0, mw1, md0, md1;
  logic [27:0]  ma0, ma1;
  logic [127:0] mwd0, mwd1, mrd0, mrd1;
  logic [3:0]   ms0, ms1;

  l1_dm_cache #(.WRITE_BACK(1)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy0),
    .resp_done(dn0), .resp_rdata(rd0), .mem_req(mq0), .mem_write(mw0),
    .mem_line_addr(ma0), .mem_wdata(mwd0), .mem_wstrb(ms0),
    .mem_done(md0), .mem_rdata(mrd0));

  l1_dm_cache #(.WRITE_BACK(0)) u1 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(rdy1),
    .resp_done(dn1), .resp_rdata(rd1), .mem_req(mq1), .mem_write(mw1),
    .mem_line_addr(ma1), .mem_wdata(mwd1), .mem_wstrb(ms1),
    .mem_done(md1), .mem_rdata(mrd1));

  sim_l1_lower m0 (.clk(clk), .rst(rst), .req(mq0), .wr(mw0), .laddr(ma0),
    .wdata(mwd0), .wstrb(ms0), .done(md0), .rdata(mrd0));
  sim_l1_lower m1 (.clk(clk), .rst(rst), .req(mq1), .wr(mw1), .laddr(ma1),
    .wdata(mwd1), .wstrb(ms1), .done(md1), .rdata(mrd1));

  int checks = 0, fails = 0;
  logic [31:0] ref_mem [logic [31:0]];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(input logic [31:0] a);
    logic [31:0] k;
    k = {a[31:2], 2'b00};
    if (ref_mem.exists(k)) return ref_mem[k];
    return init_word(k);
  endfunction

  function automatic string lat_tag(input int e);
    if (e == 1)  return "R3";
    if (e == 11) return "R5/R8/R10";
    return "R6/R9";
  endfunction

  // One access on both policies; optionally pushes a stray request while busy.
  task automatic access(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        input int e0, input int e1, input bit intrude);
    int lat, l0, l1;
    logic [31:0] d0, d1, exp;
    exp = ref_read(addr);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0; l0 = 0; l1 = 0; d0 = '0; d1 = '0;
    while ((l0 == 0 || l1 == 0) && lat < 100) begin
      @(negedge clk);
      lat++;
      if (intrude && lat == 3) begin
        // R11: stray request while both copies are busy
        req_valid = 1'b1; req_write = 1'b1; req_addr = 32'h0000_0044; req_wdata = 32'hDEAD_DEAD;
      end
      if (intrude && lat == 4) req_valid = 1'b0;
      if (dn0 && l0 == 0) begin l0 = lat; d0 = rd0; end
      if (dn1 && l1 == 0) begin l1 = lat; d1 = rd1; end
    end
    check(l0 == e0, lat_tag(e0), "write-back latency", l0, e0);
    check(l1 == e1, lat_tag(e1), "write-through latency", l1, e1);
    if (!wr) begin
      // R12 and R1: data comes from the right line and word
      check(d0 == exp, "R12", "write-back read data", d0, exp);
      check(d1 == exp, "R12", "write-through read data", d1, exp);
    end else begin
      ref_mem[{addr[31:2], 2'b00}] = wd;
    end
  endtask

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic [7:0]  lat_wb;
    logic [7:0]  lat_wt;
  } vec_t;

  // A=0x1000, B=0x9000, C=0x11000 share index 0x100 with tags 0, 1, 2.
  localparam vec_t VECS [17] = '{
    '{1'b0, 32'h0000_1000, 32'h0,          8'd11, 8'd11}, // R2 R5 R8 cold miss
    '{1'b0, 32'h0000_1004, 32'h0,          8'd1,  8'd1 }, // R3 hit
    '{1'b1, 32'h0000_1008, 32'hC0DE_0008,  8'd1,  8'd11}, // R7 / R10 write hit
    '{1'b0, 32'h0000_1008, 32'h0,          8'd1,  8'd1 }, // R12
    '{1'b0, 32'h0000_9000, 32'h0,          8'd21, 8'd11}, // R6 dirty victim / R10 none
    '{1'b0, 32'h0000_900C, 32'h0,          8'd1,  8'd1 }, // R3
    '{1'b0, 32'h0000_1000, 32'h0,          8'd11, 8'd11}, // R5 clean victim, R7 refetch
    '{1'b1, 32'h0001_1004, 32'hBEEF_0104,  8'd11, 8'd21}, // R5 write miss / R9
    '{1'b0, 32'h0001_1004, 32'h0,          8'd1,  8'd1 }, // R12
    '{1'b0, 32'h0000_1008, 32'h0,          8'd21, 8'd11}, // R6 / R8
    '{1'b0, 32'h0001_1004, 32'h0,          8'd11, 8'd11}, // R7 written-back data
    '{1'b1, 32'h0000_0020, 32'h1234_5678,  8'd11, 8'd21}, // R9 invalid victim
    '{1'b1, 32'h0000_0024, 32'h0BAD_F00D,  8'd1,  8'd11}, // R10
    '{1'b0, 32'h0000_0020, 32'h0,          8'd1,  8'd1 }, // R12
    '{1'b1, 32'hFFFF_FFFC, 32'hFACE_B00C,  8'd11, 8'd21}, // R1 top index, max tag
    '{1'b0, 32'h0000_7FF8, 32'h0,          8'd21, 8'd11}, // R1 R6
    '{1'b0, 32'hFFFF_FFFC, 32'h0,          8'd11, 8'd11}  // R12
  };

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R2: idle state after reset
    check(rdy0 && rdy1, "R2", "ready after reset", {31'b0, rdy0 && rdy1}, 32'd1);
    check(!dn0 && !dn1, "R2", "done after reset", {31'b0, dn0 || dn1}, 32'd0);
    check(!mq0 && !mq1, "R2", "mem_req after reset", {31'b0, mq0 || mq1}, 32'd0);

    foreach (VECS[i])
      access(VECS[i].wr, VECS[i].addr, VECS[i].wdata,
             int'(VECS[i].lat_wb), int'(VECS[i].lat_wt), 1'b0);

    // R11: request while busy is dropped; 0x44 must keep its initial value
    access(1'b0, 32'h0000_0040, 32'h0, 11, 11, 1'b1);
    access(1'b0, 32'h0000_0044, 32'h0, 1, 1, 1'b0);

    // R2: reset mid-run turns a cached line back into a miss
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rdy0 && rdy1, "R2", "ready after second reset", {31'b0, rdy0 && rdy1}, 32'd1);
    access(1'b0, 32'h0000_1008, 32'h0, 11, 11, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule